// File: doc/BRIEF.md
# Projector-Locked Line Exposure Sequencer

This block drives the integrate strobe and the pixel-clock enable for a bank of linear image sensors. It keeps the exposures in step with a video projector. The projector's horizontal and vertical sync lines are brought into the system clock domain, each through a two-flop synchronizer. Every edge of horizontal sync, rising or falling, counts as one line event. A rising edge of vertical sync marks the start of a projected frame. While the sensor strobe is high the sensors integrate light. When the strobe falls, integration ends and the readout window opens, and the pixel-clock enable pulses throughout that window.

There are two schemes, and the mode input chooses between them.

- **Slow mode:** one exposure covers a whole projected frame. It is followed by a fixed readout, and each projected frame forms one output frame.
- **Fast mode:** the block exposes for one line event, reads out for stride-minus-one events, and repeats. In each projected frame it therefore captures every third line. The captured set moves one line later on every following projected frame. After five projected frames the block raises a one-cycle pulse to mark the end of a frame group.

The block's states are:

| State | Meaning |
|---|---|
| `ST_IDLE` | Disabled. |
| `ST_ARMED` | Enabled and waiting for the first frame start. |
| `ST_S_EXPOSE` | Slow-mode integration. |
| `ST_S_READ` | Slow-mode readout. |
| `ST_S_HOLD` | Slow mode, frame done, waiting for the next frame start. |
| `ST_F_WAIT` | Fast mode, waiting for a line of the current phase. |
| `ST_F_EXPOSE` | Fast-mode integration of one line. |
| `ST_F_READ` | Fast-mode readout. |

The transitions are:

- **enable:** `ST_IDLE` to `ST_ARMED` when go is high.
- **disable:** any state to `ST_IDLE` when go is low.
- **frame start:** a vertical-sync rise from any state other than `ST_IDLE` goes to `ST_S_EXPOSE`, `ST_F_EXPOSE` or `ST_F_WAIT`. The target depends on the newly latched mode and the next phase.
- **exposure end:** `ST_S_EXPOSE` to `ST_S_READ`.
- **slow readout end:** `ST_S_READ` to `ST_S_HOLD`.
- **phase hit:** `ST_F_WAIT` to `ST_F_EXPOSE`.
- **line end:** `ST_F_EXPOSE` to `ST_F_READ`.
- **fast readout end:** `ST_F_READ` to `ST_F_EXPOSE`.

Top module: `line_expo_seq`

## Requirements
- R1: After reset, `sns_start_o`, `readout_o` and `group_done_o` are low, and `line_idx_o` and `frame_idx_o` are 0.
- R2: Every edge of `hsync_i`, rising or falling, is one line event. `line_idx_o` increments by one on each line event and returns to 0 on every rising edge of `vsync_i`.
- R3: The behaviour of `go_i` is as follows.
  - While `go_i` is low, the block is disabled. From the first clock edge after `go_i` goes low, `sns_start_o` and `readout_o` are low, and `line_idx_o` and `frame_idx_o` are 0.
  - Once enabled, the block starts no exposure before a rising edge of `vsync_i`.
- R4: Slow mode (`mode_fast_i`=0) works as follows.
  - `sns_start_o` rises at the frame start and stays high for SLOW_EXP_TICKS line events.
  - `sns_start_o` then falls and `readout_o` is high for SLOW_READ_TICKS line events.
  - Both signals then stay low until the next frame start.
- R5: In fast mode (`mode_fast_i`=1), `sns_start_o` is high for exactly one line event, on the lines where `line_idx_o` mod STRIDE equals the current phase. `readout_o` is high for the following STRIDE-1 line events.
- R6: In fast mode, consecutive projected frames of a group run with phase 0, 1, 2, ..., wrapping modulo STRIDE. `frame_idx_o` counts 0 to GROUP-1.
- R7: `group_done_o` is a single-cycle pulse at a frame start that closes a captured frame. This happens for every slow frame, and for a fast frame when `frame_idx_o` was GROUP-1. The frame index and the phase then return to 0.
- R8: `mode_fast_i` is sampled only on a rising edge of `vsync_i`. A change of mode restarts the frame index and the phase at 0, and it raises no `group_done_o` for an unfinished fast group.
- R9: `sns_start_o` and `readout_o` are never high together.
- R10: `pix_ce_o` pulses only while `readout_o` is high. Consecutive pulses are exactly PIX_DIV clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsync_i | input | 1 | Projector horizontal sync, asynchronous |
| vsync_i | input | 1 | Projector vertical sync, asynchronous |
| mode_fast_i | input | 1 | 1 selects line-interleaved mode, 0 selects full-frame mode |
| go_i | input | 1 | Enables the sequencer |
| sns_start_o | output | 1 | Sensor integrate strobe |
| readout_o | output | 1 | Readout window active |
| pix_ce_o | output | 1 | Pixel clock enable during readout |
| line_idx_o | output | LINE_W | Line events since the frame start |
| frame_idx_o | output | FRAME_W | Projected frame within the group |
| group_done_o | output | 1 | One-cycle pulse when a frame group completes |

## Verification
The assertions check, on every cycle:

- that the strobe and the readout flag are never both high;
- that disabling the block clears both outputs on the next cycle;
- that the group-complete pulse lasts a single cycle;
- that the frame index stays within the group size;
- that pixel enables occur only inside readout, with the exact divider spacing.

Only the bench scenarios can show the order of events. These are:

- where an exposure lands inside a frame;
- the one-line shift of the phase from frame to frame and its wrap;
- the timing of the group pulse after the fifth frame;
- that a mode change is deferred to the next frame start.

// File: rtl/line_expo_seq_pkg.sv
package line_expo_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ARMED    = 3'd1,
        ST_S_EXPOSE = 3'd2,
        ST_S_READ   = 3'd3,
        ST_S_HOLD   = 3'd4,
        ST_F_WAIT   = 3'd5,
        ST_F_EXPOSE = 3'd6,
        ST_F_READ   = 3'd7
    } seq_state_e;

endpackage

// File: rtl/seq_edge_sync.sv
module seq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic rise_o,
    output logic any_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_i;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;
    assign any_o  = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/seq_pix_div.sv
module seq_pix_div #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic ce_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!en_i)        cnt_q <= '0;
        else if (cnt_q == TOP) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign ce_o = en_i && (cnt_q == TOP);
endmodule

// File: rtl/seq_group_ctr.sv
module seq_group_ctr #(
    parameter int STRIDE  = 3,
    parameter int GROUP   = 5,
    parameter int FRAME_W = 3,
    parameter int PHASE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               frame_i,
    input  logic               prev_live_i,
    input  logic               prev_fast_i,
    input  logic               new_fast_i,
    output logic [FRAME_W-1:0] frame_idx_o,
    output logic [PHASE_W-1:0] phase_o,
    output logic [PHASE_W-1:0] nxt_phase_o,
    output logic               done_o
);
    localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(GROUP - 1);
    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(STRIDE - 1);

    logic [FRAME_W-1:0] idx_q, idx_n;
    logic [PHASE_W-1:0] ph_q, ph_n;
    logic               done_q, closes, restart;

    always_comb begin
        closes  = prev_live_i && (!prev_fast_i || idx_q == LAST_FRAME);
        restart = !prev_live_i || (prev_fast_i != new_fast_i) || closes;
        idx_n   = restart ? '0 : idx_q + 1'b1;
        if (restart)                ph_n = '0;
        else if (ph_q == LAST_PHASE) ph_n = '0;
        else                         ph_n = ph_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            ph_q   <= '0;
            done_q <= 1'b0;
        end else if (clr_i) begin
            idx_q  <= '0;
            ph_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= frame_i && closes;
            if (frame_i) begin
                idx_q <= idx_n;
                ph_q  <= ph_n;
            end
        end
    end

    assign frame_idx_o = idx_q;
    assign phase_o     = ph_q;
    assign nxt_phase_o = ph_n;
    assign done_o      = done_q;
endmodule

// File: rtl/line_expo_seq.sv
module line_expo_seq #(
    parameter int LINE_W          = 12,
    parameter int FRAME_W         = 3,
    parameter int STRIDE          = 3,
    parameter int GROUP           = 5,
    parameter int SLOW_EXP_TICKS  = 1000,
    parameter int SLOW_READ_TICKS = 40,
    parameter int PIX_DIV         = 10,
    parameter int SYNC_STAGES     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hsync_i,
    input  logic               vsync_i,
    input  logic               mode_fast_i,
    input  logic               go_i,
    output logic               sns_start_o,
    output logic               readout_o,
    output logic               pix_ce_o,
    output logic [LINE_W-1:0]  line_idx_o,
    output logic [FRAME_W-1:0] frame_idx_o,
    output logic               group_done_o
);
    import line_expo_seq_pkg::*;

    localparam int PHASE_W = (STRIDE > 2) ? $clog2(STRIDE) : 1;
    localparam int RD_W    = (SLOW_READ_TICKS > STRIDE) ? $clog2(SLOW_READ_TICKS + 1)
                                                        : $clog2(STRIDE + 1);
    localparam logic [LINE_W-1:0]  EXP_END   = LINE_W'(SLOW_EXP_TICKS);
    localparam logic [RD_W-1:0]    SRD_END   = RD_W'(SLOW_READ_TICKS);
    localparam logic [RD_W-1:0]    FRD_END   = RD_W'(STRIDE - 1);
    localparam logic [PHASE_W-1:0] MOD_LAST  = PHASE_W'(STRIDE - 1);
    localparam logic [LINE_W-1:0]  LINE_MAX  = {LINE_W{1'b1}};

    seq_state_e         state_q, state_n;
    logic               vs_rise, ln_tick, hs_rise_unused;
    logic [LINE_W-1:0]  line_q, line_inc;
    logic [PHASE_W-1:0] mod_q, mod_inc;
    logic [RD_W-1:0]    rd_q, rd_inc;
    logic               mode_q, live_q;
    logic [PHASE_W-1:0] phase, nxt_phase;
    logic               frame_evt, active;

    seq_edge_sync #(.STAGES(SYNC_STAGES)) u_hs_sync (
        .clk(clk), .rst_n(rst_n), .d_i(hsync_i),
        .rise_o(hs_rise_unused), .any_o(ln_tick)
    );

    logic vs_any_unused;
    seq_edge_sync #(.STAGES(SYNC_STAGES)) u_vs_sync (
        .clk(clk), .rst_n(rst_n), .d_i(vsync_i),
        .rise_o(vs_rise), .any_o(vs_any_unused)
    );

    assign active    = (state_q != ST_IDLE);
    assign frame_evt = go_i && active && vs_rise;

    seq_group_ctr #(
        .STRIDE(STRIDE), .GROUP(GROUP), .FRAME_W(FRAME_W), .PHASE_W(PHASE_W)
    ) u_group (
        .clk(clk), .rst_n(rst_n), .clr_i(!go_i), .frame_i(frame_evt),
        .prev_live_i(live_q), .prev_fast_i(mode_q), .new_fast_i(mode_fast_i),
        .frame_idx_o(frame_idx_o), .phase_o(phase), .nxt_phase_o(nxt_phase),
        .done_o(group_done_o)
    );

    // Counter increments shared by the next-state logic
    always_comb begin
        line_inc = (line_q == LINE_MAX) ? line_q : line_q + 1'b1;
        mod_inc  = (mod_q == MOD_LAST) ? '0 : mod_q + 1'b1;
        rd_inc   = rd_q + 1'b1;
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        if (!go_i) begin
            state_n = ST_IDLE;
        end else if (state_q == ST_IDLE) begin
            state_n = ST_ARMED;
        end else if (vs_rise) begin
            if (!mode_fast_i)            state_n = ST_S_EXPOSE;
            else if (nxt_phase == '0)    state_n = ST_F_EXPOSE;
            else                         state_n = ST_F_WAIT;
        end else if (ln_tick) begin
            unique case (state_q)
                ST_S_EXPOSE: if (line_inc == EXP_END) state_n = ST_S_READ;
                ST_S_READ:   if (rd_inc == SRD_END)   state_n = ST_S_HOLD;
                ST_F_WAIT:   if (mod_inc == phase)    state_n = ST_F_EXPOSE;
                ST_F_EXPOSE:                          state_n = ST_F_READ;
                ST_F_READ:   if (rd_inc == FRD_END)   state_n = ST_F_EXPOSE;
                default:                              state_n = state_q;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // Line, phase-modulo and readout counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
            mod_q  <= '0;
            rd_q   <= '0;
            mode_q <= 1'b0;
            live_q <= 1'b0;
        end else if (!go_i || state_q == ST_IDLE) begin
            line_q <= '0;
            mod_q  <= '0;
            rd_q   <= '0;
            live_q <= 1'b0;
        end else if (vs_rise) begin
            line_q <= '0;
            mod_q  <= '0;
            rd_q   <= '0;
            mode_q <= mode_fast_i;
            live_q <= 1'b1;
        end else if (ln_tick) begin
            line_q <= line_inc;
            mod_q  <= mod_inc;
            if (state_q == ST_S_READ || state_q == ST_F_READ) rd_q <= rd_inc;
            else                                              rd_q <= '0;
        end
    end

    // Output decode
    always_comb begin
        sns_start_o = 1'b0;
        readout_o   = 1'b0;
        unique case (state_q)
            ST_S_EXPOSE, ST_F_EXPOSE: sns_start_o = 1'b1;
            ST_S_READ, ST_F_READ:     readout_o   = 1'b1;
            default: ;
        endcase
    end

    assign line_idx_o = line_q;

    seq_pix_div #(.DIV(PIX_DIV)) u_pix (
        .clk(clk), .rst_n(rst_n), .en_i(readout_o), .ce_o(pix_ce_o)
    );
endmodule

// File: rtl/line_expo_seq_chk.sv
module line_expo_seq_chk #(
    parameter int LINE_W  = 12,
    parameter int FRAME_W = 3,
    parameter int GROUP   = 5,
    parameter int PIX_DIV = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               go_i,
    input logic               sns_start_o,
    input logic               readout_o,
    input logic               pix_ce_o,
    input logic [FRAME_W-1:0] frame_idx_o,
    input logic               group_done_o
);
    localparam int GW = $clog2(PIX_DIV + 1) + 1;
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         gap_q <= GW'(PIX_DIV);
        else if (pix_ce_o)                  gap_q <= '0;
        else if (gap_q < GW'(PIX_DIV))      gap_q <= gap_q + 1'b1;
    end

    AST_START_READ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sns_start_o && readout_o)); // R9

    AST_GO_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !go_i |=> (!sns_start_o && !readout_o)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        group_done_o |=> !group_done_o); // R7

    AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_idx_o < FRAME_W'(GROUP)); // R6

    AST_PIX_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ce_o |-> readout_o); // R10

    AST_PIX_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ce_o |-> (gap_q >= GW'(PIX_DIV - 1))); // R10
endmodule

bind line_expo_seq line_expo_seq_chk #(
    .LINE_W(LINE_W), .FRAME_W(FRAME_W), .GROUP(GROUP), .PIX_DIV(PIX_DIV)
) u_chk (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .sns_start_o(sns_start_o),
    .readout_o(readout_o), .pix_ce_o(pix_ce_o), .frame_idx_o(frame_idx_o),
    .group_done_o(group_done_o)
);

// File: tb/line_expo_seq_tb_top.sv
module line_expo_seq_tb_top;
    localparam int LINE_W = 12;
    localparam int FRAME_W = 3;
    localparam int PIX_DIV = 4;
    localparam int SETTLE = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hsync = 1'b0, vsync = 1'b0, mode_fast = 1'b0, go = 1'b0;
    logic sns_start, readout, pix_ce, group_done;
    logic [LINE_W-1:0] line_idx;
    logic [FRAME_W-1:0] frame_idx;

    always #2 clk = ~clk;

    line_expo_seq #(
        .LINE_W(LINE_W), .FRAME_W(FRAME_W), .STRIDE(3), .GROUP(5),
        .SLOW_EXP_TICKS(6), .SLOW_READ_TICKS(2), .PIX_DIV(PIX_DIV), .SYNC_STAGES(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
        .mode_fast_i(mode_fast), .go_i(go), .sns_start_o(sns_start),
        .readout_o(readout), .pix_ce_o(pix_ce), .line_idx_o(line_idx),
        .frame_idx_o(frame_idx), .group_done_o(group_done)
    );

    typedef struct {
        logic  start;
        logic  rd;
        int    line;
        int    frame;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int n_tests = 0;
    int n_fail = 0;
    int done_cnt = 0;
    int cyc = 0;
    int pix_times[$];
    bit finished = 0;

    // Monitor: pops expected items and compares against the ports
    always @(negedge clk) begin
        cyc++;
        if (group_done) done_cnt++;
        if (pix_ce) pix_times.push_back(cyc);
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_tests++;
            if (sns_start !== e.start || readout !== e.rd ||
                int'(line_idx) != e.line || int'(frame_idx) != e.frame) begin
                n_fail++;
                $display("FAIL %s: got start=%0b rd=%0b line=%0d frame=%0d, expected start=%0b rd=%0b line=%0d frame=%0d",
                         e.req, sns_start, readout, line_idx, frame_idx,
                         e.start, e.rd, e.line, e.frame);
            end
        end
    end

    task automatic expect_out(input logic s, input logic r, input int ln, input int fr, input string req);
        exp_t e;
        e.start = s; e.rd = r; e.line = ln; e.frame = fr; e.req = req;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
        @(posedge clk);
    endtask

    task automatic check_val(input int got, input int want, input string req);
        n_tests++;
        if (got != want) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, want);
        end
    endtask

    task automatic line_evt();
        @(posedge clk); #1;
        hsync = ~hsync;
        repeat (SETTLE) @(posedge clk);
    endtask

    task automatic frame_evt();
        @(posedge clk); #1;
        vsync = 1'b1;
        repeat (SETTLE) @(posedge clk);
        #1;
        vsync = 1'b0;
        repeat (SETTLE) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_out(0, 0, 0, 0, "R1");
        check_val(done_cnt, 0, "R1");

        go = 1'b1; mode_fast = 1'b1;
        line_evt();
        expect_out(0, 0, 1, 0, "R3");          // armed, no exposure before frame start

        frame_evt();
        expect_out(1, 0, 0, 0, "R5");          // phase 0: line 0 exposes
        line_evt(); expect_out(0, 1, 1, 0, "R5");
        line_evt(); expect_out(0, 1, 2, 0, "R2");
        line_evt(); expect_out(1, 0, 3, 0, "R5");
        pix_times.delete();
        line_evt(); line_evt();
        n_tests++;
        if (pix_times.size() < 2 || pix_times[1] - pix_times[0] != PIX_DIV) begin
            n_fail++;
            $display("FAIL R10: pulses=%0d spacing=%0d expected spacing %0d",
                     pix_times.size(), (pix_times.size() >= 2) ? pix_times[1] - pix_times[0] : -1, PIX_DIV);
        end
        line_evt(); expect_out(1, 0, 6, 0, "R5");

        frame_evt();
        expect_out(0, 0, 0, 1, "R6");          // phase 1
        line_evt(); expect_out(1, 0, 1, 1, "R6");
        line_evt(); expect_out(0, 1, 2, 1, "R5");
        line_evt(); expect_out(0, 1, 3, 1, "R5");
        line_evt(); expect_out(1, 0, 4, 1, "R5");

        frame_evt();
        expect_out(0, 0, 0, 2, "R6");          // phase 2
        line_evt(); expect_out(0, 0, 1, 2, "R6");
        line_evt(); expect_out(1, 0, 2, 2, "R6");

        frame_evt();
        expect_out(1, 0, 0, 3, "R6");          // phase wraps to 0
        frame_evt();
        expect_out(0, 0, 0, 4, "R6");          // phase 1
        check_val(done_cnt, 0, "R7");
        frame_evt();
        check_val(done_cnt, 1, "R7");
        expect_out(1, 0, 0, 0, "R7");

        mode_fast = 1'b0;                      // deferred until frame start
        line_evt(); expect_out(0, 1, 1, 0, "R8");
        frame_evt();
        expect_out(1, 0, 0, 0, "R8");
        check_val(done_cnt, 1, "R8");

        for (int i = 0; i < 5; i++) line_evt();
        expect_out(1, 0, 5, 0, "R4");
        line_evt(); expect_out(0, 1, 6, 0, "R4");
        line_evt(); expect_out(0, 1, 7, 0, "R4");
        line_evt(); expect_out(0, 0, 8, 0, "R4");
        pix_times.delete();
        line_evt();
        check_val(pix_times.size(), 0, "R10");

        frame_evt();
        check_val(done_cnt, 2, "R7");
        expect_out(1, 0, 0, 0, "R4");

        mode_fast = 1'b1;
        frame_evt();
        check_val(done_cnt, 3, "R7");
        expect_out(1, 0, 0, 0, "R8");

        @(posedge clk); #1 go = 1'b0;
        @(posedge clk);
        expect_out(0, 0, 0, 0, "R3");
        line_evt(); expect_out(0, 0, 0, 0, "R3");
        frame_evt(); expect_out(0, 0, 0, 0, "R3");

        @(posedge clk); #1 go = 1'b1;
        repeat (2) @(posedge clk);
        frame_evt();
        expect_out(1, 0, 0, 0, "R3");
        check_val(done_cnt, 3, "R3");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule